// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. The line idles high; each character opens with a low start bit, then carries five to nine data bits least significant first, an optional parity bit and one or two high stop bits. The receiver runs a sample tick at sixteen times the bit rate, from a run-time divisor. A falling edge arms it, a mid-bit re-check confirms the start bit, and each following bit is taken by a majority vote near its centre.

The completed character enters a single-entry holding buffer together with its frame and parity error status. A ready flag stays high while that character is unread and drops when the host pulses the read strobe. A character that completes while the buffer is still full is dropped and the overrun flag is raised. An enable input switches the receiver on and off with no effect on any transmit side. The frame format (character size, parity mode, stop count) is set by run-time inputs that must match the sending side.

Top module: `osr_receiver`

## Requirements
- R1: One bit period lasts 16 × (divisor + 1) clock cycles; characters are received correctly at divisor values 0, 1, 2 and 3.
- R2: The size code selects the data bit count: 000 → 5, 001 → 6, 010 → 7, 011 → 8, 111 → 9, while 100, 101 and 110 also give 8. The first data bit after the start bit lands in data bit 0, and data bits above the selected size read as 0.
- R3: A falling line edge starts a candidate frame that is kept only if the line is still low at the 8th of the 16 samples of the start bit. Otherwise it is dropped with no buffer load, and a later valid frame is still received.
- R4: Each data bit is the majority of its 7th, 8th and 9th samples, so a disturbance hitting only one of those samples leaves the bit unchanged, while one covering two of them flips it.
- R5: Parity mode code 10 selects even parity, 11 odd, 00 none; 01 behaves as none. With parity on, a parity bit follows the data and the parity error flag is set when the ones in data plus parity bit do not match the selected mode; with parity off no parity bit is expected and the flag is 0.
- R6: The frame error flag is set when the first stop bit is sampled low. The stop count input does not change reception: a new start bit right after a single stop bit is received even when two stop bits are selected.
- R7: The ready flag rises when a character is loaded and stays high until a read strobe; a read strobe clears it on the next clock edge, and a read strobe with an empty buffer changes nothing.
- R8: When a character completes while the buffer is unread, the new character is discarded, the held data is kept and the overrun flag is set.
- R9: While the enable input is low, no frame is received and the buffer is not loaded.
- R10: After reset the ready flag and all three error flags are 0.
- R11: The frame error, parity error and overrun flags are rewritten on every buffer load, so a clean character clears flags left by an earlier one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receiver on/off |
| divisor | input | DIV_W (12) | Tick divisor; bit period is 16 × (divisor + 1) clocks |
| par_mode | input | 2 | 00 none, 10 even, 11 odd, 01 treated as none |
| two_stop | input | 1 | Stop count of the format; does not alter reception |
| size_code | input | 3 | Data bit count code (see R2) |
| rx_line | input | 1 | Serial input, idle high |
| rd_stb | input | 1 | One-cycle read of the buffered character |
| rx_data | output | 9 | Buffered character, upper unused bits zero |
| rx_ready | output | 1 | Unread character present |
| err_frame | output | 1 | First stop bit of the buffered character was low |
| err_overrun | output | 1 | A character was dropped since the last load |
| err_parity | output | 1 | Parity mismatch on the buffered character |

## Verification
A table of frames spans every size code group, all four parity codes, both stop settings and four divisor values, with data chosen so that masking of unused bits, bit order and parity polarity each give a different read-back value. Frames with a flipped parity bit or a low first stop bit separate the two error flags from each other, and the next clean frame shows both are refreshed. Directed cases cover a short low pulse on an idle line (rejected start), a one-sample against a two-sample disturbance inside a data bit (the majority vote), two frames back to back with no read (overrun with the first character kept), and a frame sent while disabled.

// File: rtl/osr_pkg.sv
`timescale 1ns/1ps
package osr_pkg;

    localparam int CHAR_MAX = 9;
    localparam int LEN_W    = $clog2(CHAR_MAX + 1);
    localparam int OSR      = 16;
    localparam int SMP_W    = $clog2(OSR);

    localparam logic [SMP_W-1:0] SMP_EARLY = SMP_W'(OSR / 2 - 2);
    localparam logic [SMP_W-1:0] SMP_MID   = SMP_W'(OSR / 2 - 1);
    localparam logic [SMP_W-1:0] SMP_LATE  = SMP_W'(OSR / 2);
    localparam logic [SMP_W-1:0] SMP_LAST  = SMP_W'(OSR - 1);

    typedef enum logic [1:0] {
        PAR_OFF  = 2'b00,
        PAR_RSVD = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_MAX-1:0] bits;
        logic                stop_bad;
        logic                par_bad;
    } rx_char_t;

    function automatic logic [LEN_W-1:0] char_len(input logic [2:0] code);
        logic [LEN_W-1:0] n;
        case (code)
            3'b000:  n = LEN_W'(5);
            3'b001:  n = LEN_W'(6);
            3'b010:  n = LEN_W'(7);
            3'b111:  n = LEN_W'(9);
            default: n = LEN_W'(8);
        endcase
        return n;
    endfunction

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic par_used(input par_mode_e m);
        return (m == PAR_EVEN) || (m == PAR_ODD);
    endfunction

    // ones_odd: odd count of ones over data and parity bit
    function automatic logic par_mismatch(input par_mode_e m, input logic ones_odd);
        logic bad;
        case (m)
            PAR_EVEN: bad = ones_odd;
            PAR_ODD:  bad = ~ones_odd;
            default:  bad = 1'b0;
        endcase
        return bad;
    endfunction

endpackage

// File: rtl/osr_line_sync.sv
`timescale 1ns/1ps
module osr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic line_o,
    output logic fall_o
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) pipe <= 1'b1;
                else     pipe <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) pipe <= '1;
                else     pipe <= {pipe[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= pipe[STAGES-1];
    end

    assign line_o = pipe[STAGES-1];
    assign fall_o = prev & ~pipe[STAGES-1];

endmodule

// File: rtl/osr_tick_gen.sv
`timescale 1ns/1ps
module osr_tick_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap   = (cnt >= div_i);
    assign tick_o = en & ~clr & wrap;

    always_ff @(posedge clk) begin
        if (rst || !en || clr) cnt <= '0;
        else if (wrap)         cnt <= '0;
        else                   cnt <= cnt + DIV_W'(1);
    end

    // R1: with a nonzero, unchanged divisor two ticks are never adjacent
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div_i != '0) |=> (!tick_o || div_i != $past(div_i)));

endmodule

// File: rtl/osr_frame_fsm.sv
`timescale 1ns/1ps
module osr_frame_fsm
    import osr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             line_i,
    input  logic             fall_i,
    input  logic             tick_i,
    input  logic [LEN_W-1:0] len_i,
    input  par_mode_e        mode_i,
    output logic             start_o,
    output logic             done_o,
    output rx_char_t         char_o
);
    rx_state_e           state;
    logic [SMP_W-1:0]    s_cnt;
    logic [LEN_W-1:0]    bit_idx;
    logic [1:0]          smp;
    logic [CHAR_MAX-1:0] shreg;
    logic                par_bit;
    logic                vote;

    assign vote    = maj3(smp[0], smp[1], line_i);
    assign start_o = en && (state == ST_IDLE) && fall_i;
    assign done_o  = en && (state == ST_STOP) && tick_i && (s_cnt == SMP_LATE);

    assign char_o.bits     = shreg;
    assign char_o.stop_bad = ~vote;
    assign char_o.par_bad  = par_mismatch(mode_i, (^shreg) ^ par_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            s_cnt   <= '0;
            bit_idx <= '0;
            smp     <= 2'b11;
            shreg   <= '0;
            par_bit <= 1'b0;
        end else if (!en) begin
            state <= ST_IDLE;
            s_cnt <= '0;
        end else if (state == ST_IDLE) begin
            if (fall_i) begin
                state   <= ST_START;
                s_cnt   <= '0;
                bit_idx <= '0;
                shreg   <= '0;
                par_bit <= 1'b0;
            end
        end else if (tick_i) begin
            s_cnt <= s_cnt + SMP_W'(1);
            if (s_cnt == SMP_EARLY) smp[0] <= line_i;
            if (s_cnt == SMP_MID)   smp[1] <= line_i;
            case (state)
                ST_START: begin
                    if (s_cnt == SMP_MID && line_i) state <= ST_IDLE;
                    else if (s_cnt == SMP_LAST) begin
                        state   <= ST_DATA;
                        bit_idx <= '0;
                    end
                end
                ST_DATA: begin
                    if (s_cnt == SMP_LATE) shreg[bit_idx] <= vote;
                    if (s_cnt == SMP_LAST) begin
                        if (bit_idx == len_i - LEN_W'(1))
                            state <= par_used(mode_i) ? ST_PAR : ST_STOP;
                        else
                            bit_idx <= bit_idx + LEN_W'(1);
                    end
                end
                ST_PAR: begin
                    if (s_cnt == SMP_LATE) par_bit <= vote;
                    if (s_cnt == SMP_LAST) state <= ST_STOP;
                end
                ST_STOP: begin
                    if (s_cnt == SMP_LATE) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: a disabled receiver is back in idle on the next edge
    p_off_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> state == ST_IDLE);

    // R3: a start bit seen high at its middle sample is abandoned
    p_glitch_abort_r3: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_START && tick_i && s_cnt == SMP_MID && line_i)
        |=> state == ST_IDLE);

    // R6: one completion per frame, followed by idle
    p_done_to_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (state == ST_IDLE && !done_o));

endmodule

// File: rtl/osr_rx_buffer.sv
`timescale 1ns/1ps
module osr_rx_buffer
    import osr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  rx_char_t            char_i,
    input  logic                rd_i,
    output logic                full_o,
    output logic [CHAR_MAX-1:0] data_o,
    output logic                fe_o,
    output logic                pe_o,
    output logic                ovr_o
);
    rx_char_t held;
    logic     full;
    logic     ovr;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            full <= 1'b0;
            ovr  <= 1'b0;
        end else if (load_i) begin
            if (full && !rd_i) begin
                ovr <= 1'b1;
            end else begin
                held <= char_i;
                full <= 1'b1;
                ovr  <= 1'b0;
            end
        end else if (rd_i) begin
            full <= 1'b0;
        end
    end

    assign full_o = full;
    assign data_o = held.bits;
    assign fe_o   = held.stop_bad;
    assign pe_o   = held.par_bad;
    assign ovr_o  = ovr;

    // R7: unread data stays flagged
    p_ready_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (full_o && !rd_i) |=> full_o);

    // R7: a read with no competing load empties the buffer
    p_ready_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (full_o && rd_i && !load_i) |=> !full_o);

    // R8: a character arriving at a full buffer is dropped
    p_ovr_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (full_o && load_i && !rd_i) |=> (ovr_o && full_o && $stable(data_o)));

endmodule

// File: rtl/osr_receiver.sv
`timescale 1ns/1ps
module osr_receiver
    import osr_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_en,
    input  logic [DIV_W-1:0]    divisor,
    input  logic [1:0]          par_mode,
    input  logic                two_stop,
    input  logic [2:0]          size_code,
    input  logic                rx_line,
    input  logic                rd_stb,
    output logic [CHAR_MAX-1:0] rx_data,
    output logic                rx_ready,
    output logic                err_frame,
    output logic                err_overrun,
    output logic                err_parity
);
    logic      line_s;
    logic      fall_s;
    logic      tick;
    logic      start;
    logic      done;
    rx_char_t  rx_char;
    logic      stop_sel_unused;

    // the stop count only matters to a sender; reception checks the first stop bit
    assign stop_sel_unused = two_stop;

    osr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (rx_line),
        .line_o (line_s),
        .fall_o (fall_s)
    );

    osr_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .en     (rx_en),
        .clr    (start),
        .div_i  (divisor),
        .tick_o (tick)
    );

    osr_frame_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en      (rx_en),
        .line_i  (line_s),
        .fall_i  (fall_s),
        .tick_i  (tick),
        .len_i   (char_len(size_code)),
        .mode_i  (par_mode_e'(par_mode)),
        .start_o (start),
        .done_o  (done),
        .char_o  (rx_char)
    );

    osr_rx_buffer u_buf (
        .clk    (clk),
        .rst    (rst),
        .load_i (done),
        .char_i (rx_char),
        .rd_i   (rd_stb),
        .full_o (rx_ready),
        .data_o (rx_data),
        .fe_o   (err_frame),
        .pe_o   (err_parity),
        .ovr_o  (err_overrun)
    );

endmodule

// File: tb/osr_receiver_tb.sv
`timescale 1ns/1ps
module osr_receiver_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_en;
    logic [11:0] divisor;
    logic [1:0] par_mode;
    logic       two_stop;
    logic [2:0] size_code;
    logic       rx_line;
    logic       rd_stb;
    logic [8:0] rx_data;
    logic       rx_ready;
    logic       err_frame;
    logic       err_overrun;
    logic       err_parity;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    osr_receiver u_dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .divisor(divisor),
        .par_mode(par_mode), .two_stop(two_stop), .size_code(size_code),
        .rx_line(rx_line), .rd_stb(rd_stb), .rx_data(rx_data),
        .rx_ready(rx_ready), .err_frame(err_frame),
        .err_overrun(err_overrun), .err_parity(err_parity)
    );

    typedef struct packed {
        logic [1:0] div;
        logic [2:0] code;
        logic [1:0] par;
        logic       stop2;
        logic [8:0] data;
        logic       flip;
        logic       bad_stop;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 3'b011, 2'b00, 1'b0, 9'h0A5, 1'b0, 1'b0},
        '{2'd0, 3'b000, 2'b10, 1'b0, 9'h1F3, 1'b0, 1'b0},
        '{2'd3, 3'b010, 2'b11, 1'b1, 9'h05A, 1'b0, 1'b0},
        '{2'd1, 3'b111, 2'b10, 1'b0, 9'h1C6, 1'b0, 1'b0},
        '{2'd1, 3'b011, 2'b11, 1'b0, 9'h03C, 1'b1, 1'b0},
        '{2'd1, 3'b001, 2'b00, 1'b0, 9'h02D, 1'b0, 1'b1},
        '{2'd1, 3'b011, 2'b10, 1'b0, 9'h081, 1'b0, 1'b0},
        '{2'd0, 3'b011, 2'b01, 1'b0, 9'h055, 1'b1, 1'b0},
        '{2'd2, 3'b110, 2'b00, 1'b1, 9'h0F0, 1'b0, 1'b1},
        '{2'd0, 3'b011, 2'b10, 1'b0, 9'h000, 1'b0, 1'b0}
    };

    function automatic int width_of(input logic [2:0] code);
        case (code)
            3'b000:  return 5;
            3'b001:  return 6;
            3'b010:  return 7;
            3'b111:  return 9;
            default: return 8;
        endcase
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] mask_to(input logic [8:0] d, input int w);
        return d & ((9'h1 << w) - 9'h1);
    endfunction

    // drive one frame; glitch inverts frame bit gbit for clocks [g0, g0+glen)
    task automatic send(input logic [8:0] d, input int nstop, input bit flip,
                        input bit bad_stop, input int gbit, input int g0, input int glen);
        logic [15:0] fr;
        int n;
        int w;
        int bp;
        logic [8:0] dm;
        w  = width_of(size_code);
        bp = 16 * (int'(divisor) + 1);
        dm = mask_to(d, w);
        fr = '1;
        fr[0] = 1'b0;
        for (int i = 0; i < w; i++) fr[1 + i] = dm[i];
        n = 1 + w;
        if (par_mode[1]) begin
            fr[n] = (^dm) ^ par_mode[0] ^ flip;
            n++;
        end
        fr[n] = ~bad_stop;
        n++;
        if (nstop == 2) begin
            fr[n] = 1'b1;
            n++;
        end
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < bp; c++) begin
                rx_line = fr[k] ^ ((k == gbit) && (c >= g0) && (c < g0 + glen));
                step(1);
            end
        end
        rx_line = 1'b1;
    endtask

    task automatic idle_bits(input int nb);
        step(nb * 16 * (int'(divisor) + 1));
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        step(1);
        rd_stb = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rx_en = 1'b1; divisor = 12'd1; par_mode = 2'b00;
        two_stop = 1'b0; size_code = 3'b011; rx_line = 1'b1; rd_stb = 1'b0;
        step(4);
        rst = 1'b0;
        step(2);

        // R10 reset state
        chk("R10 ready after reset", 16'(rx_ready), 16'h0);
        chk("R10 frame err after reset", 16'(err_frame), 16'h0);
        chk("R10 parity err after reset", 16'(err_parity), 16'h0);
        chk("R10 overrun after reset", 16'(err_overrun), 16'h0);

        // R7 read of an empty buffer changes nothing
        do_read();
        chk("R7 empty read", 16'(rx_ready), 16'h0);

        // table: R1 R2 R5 R6 R11
        for (int v = 0; v < NV; v++) begin
            int w;
            logic pe_exp;
            divisor   = 12'(VECS[v].div);
            size_code = VECS[v].code;
            par_mode  = VECS[v].par;
            two_stop  = VECS[v].stop2;
            step(2);
            w = width_of(VECS[v].code);
            pe_exp = VECS[v].flip && VECS[v].par[1];
            send(VECS[v].data, VECS[v].stop2 ? 2 : 1, VECS[v].flip, VECS[v].bad_stop, -1, 0, 0);
            idle_bits(2);
            chk("R7 ready after frame", 16'(rx_ready), 16'h1);
            chk("R1 R2 data", 16'(rx_data), 16'(mask_to(VECS[v].data, w)));
            chk("R5 parity flag", 16'(err_parity), 16'(pe_exp));
            chk("R6 frame flag", 16'(err_frame), 16'(VECS[v].bad_stop));
            chk("R11 overrun refreshed", 16'(err_overrun), 16'h0);
            do_read();
            chk("R7 ready cleared by read", 16'(rx_ready), 16'h0);
        end

        // R8 and R6: two frames back to back, one stop bit although two selected
        divisor = 12'd1; size_code = 3'b011; par_mode = 2'b00; two_stop = 1'b1;
        step(2);
        send(9'h011, 1, 1'b0, 1'b0, -1, 0, 0);
        send(9'h022, 1, 1'b0, 1'b0, -1, 0, 0);
        idle_bits(2);
        chk("R8 ready kept", 16'(rx_ready), 16'h1);
        chk("R8 first char kept", 16'(rx_data), 16'h011);
        chk("R8 R6 overrun from back-to-back frame", 16'(err_overrun), 16'h1);
        do_read();
        send(9'h033, 1, 1'b0, 1'b0, -1, 0, 0);
        idle_bits(2);
        chk("R11 overrun cleared by load", 16'(err_overrun), 16'h0);
        chk("R11 new data", 16'(rx_data), 16'h033);
        do_read();

        // R3 short low pulse on idle line
        two_stop = 1'b0;
        rx_line = 1'b0;
        step(6);
        rx_line = 1'b1;
        idle_bits(3);
        chk("R3 glitch not loaded", 16'(rx_ready), 16'h0);
        send(9'h05A, 1, 1'b0, 1'b0, -1, 0, 0);
        idle_bits(2);
        chk("R3 frame after glitch", 16'(rx_data), 16'h05A);
        chk("R3 ready after glitch", 16'(rx_ready), 16'h1);
        do_read();

        // R4 majority: divisor 3, data bit 3 is frame bit 4
        divisor = 12'd3;
        step(2);
        send(9'h0FF, 1, 1'b0, 1'b0, 4, 30, 4);
        idle_bits(2);
        chk("R4 single sample disturbance", 16'(rx_data), 16'h0FF);
        do_read();
        send(9'h0FF, 1, 1'b0, 1'b0, 4, 30, 8);
        idle_bits(2);
        chk("R4 two sample disturbance", 16'(rx_data), 16'h0F7);
        do_read();

        // R9 disabled receiver
        divisor = 12'd1;
        rx_en = 1'b0;
        step(2);
        send(9'h0C3, 1, 1'b0, 1'b0, -1, 0, 0);
        idle_bits(2);
        chk("R9 no load while disabled", 16'(rx_ready), 16'h0);
        rx_en = 1'b1;
        step(2);
        send(9'h03C, 1, 1'b0, 1'b0, -1, 0, 0);
        idle_bits(2);
        chk("R9 load after re-enable", 16'(rx_data), 16'h03C);
        do_read();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule